// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts hardware events for profiling. It holds a small bank of 32-bit counters, each of which follows one event number chosen by software. Event pulses arrive as a 64-wide vector indexed by event number. One event number is reserved for the clock-cycle tick, which can optionally be divided by 64. A privilege input lets each counter leave out events that occur in privileged mode, in user mode, or in both.

Software reaches the block through a simple word-addressed register bus with combinational read data. The event-type and count registers of the counters share two addresses, and a select register chooses which counter they refer to. Counter enables and interrupt enables each have their own set and clear addresses. Wraps are recorded in a status register that is cleared by writing ones. An interrupt is raised while an enabled counter has a recorded wrap. To sample every N events, software preloads a counter with a value just below 2^32.

Top module: `evmon_top`

Register map (word address on `bus_addr`): 0 control (bit 0 run, bit 3 tick divide-by-64), 1 count-enable set, 2 count-enable clear, 3 irq-enable set, 4 irq-enable clear, 5 wrap status (write one to clear), 6 counter select (bits 4:0), 7 selected event type, 8 selected count, 9 capability low (events 31..0), 10 capability high (events 63..32). Unmapped addresses read 0.

## Requirements
- R1: While control bit 0 is 0, no counter advances on any event or tick; once it is 1 again, counting resumes.
- R2: Event number 0x11 counts the cycle tick. When control bit 3 is 0, every tick counts. When it is 1, only every 64th tick counts: after bit 3 is set, the 64th tick is the first one counted.
- R3: The event-type register keeps the event number in bits 7:0. Bit 31 = 1 blocks counting while `priv_mode` is 1, and bit 30 = 1 blocks counting while `priv_mode` is 0. All other bits read as 0.
- R4: Writing the select register (address 6) routes addresses 7 and 8 to that counter. For a select value of 4 or more, reads of addresses 7 and 8 return 0 and writes to them change no counter.
- R5: Writing a 1 to a bit of address 1 (or 3) sets that counter's count-enable (or irq-enable) bit. Writing a 1 to the same bit of address 2 (or 4) clears it. Zero bits change nothing. Both addresses of a pair read back the current mask.
- R6: When a counter steps from 0xFFFFFFFF to 0, its bit in the wrap status register (address 5) is set. Writing 1 to a status bit clears it, and writing 0 leaves it set.
- R7: `irq_o` is 1 exactly while some counter has both its wrap status bit and its irq-enable bit set.
- R8: Addresses 9 and 10 return the implemented-event map (the default parameter gives 0x000200FF and 0x00000001). A counter whose event number is unimplemented, or 64 and above, never advances.
- R9: A write to address 8 loads the selected counter. Each matching, enabled event pulse adds exactly one, taking effect at the clock edge where the pulse is sampled.
- R10: Reset clears control, selection, all enables, all status bits, all event types and all counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| events_in | input | 64 | One pulse bit per event number |
| priv_mode | input | 1 | 1 = processor privileged, 0 = user |
| cycle_tick | input | 1 | Clock-cycle tick pulse |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a wrap: from reset, reaching one by counting alone would take 2^32 events. The stimulus preloads a counter with 0xFFFFFFFE, so two pulses carry it through the wrap, and the interrupt is then checked while its enable is cleared and set again. The divide-by-64 mode is reached by first counting ticks undivided, then setting the divide bit and applying 63 ticks, which must not count, followed by the 64th tick, which must. The events at or above 64 and the select values beyond the last counter are reached through indirect accesses. A value written to a missing counter must then not appear in the real one.

// File: rtl/evmon_pkg.sv
// Shared constants of the event-counter monitor: register word addresses,
// event-type field positions and the reserved cycle-tick event number.
// Assumes a 4-bit word address bus and 32-bit data.
package evmon_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int NUM_EVT   = 64;
    localparam int SEL_W     = 5;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_ENSET  = 4'd1;
    localparam logic [ADDR_W-1:0] A_ENCLR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_IESET  = 4'd3;
    localparam logic [ADDR_W-1:0] A_IECLR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_WRAP   = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEL    = 4'd6;
    localparam logic [ADDR_W-1:0] A_TYPE   = 4'd7;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CAPLO  = 4'd9;
    localparam logic [ADDR_W-1:0] A_CAPHI  = 4'd10;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_DIV_BIT = 3;
    localparam int TYPE_NOPRIV_BIT = 31;
    localparam int TYPE_NOUSER_BIT = 30;

    localparam logic [7:0] CYCLE_EVT = 8'h11;
endpackage

// File: rtl/evmon_prescale.sv
// Cycle-tick prescaler. Passes every tick through while division is off;
// with division on, passes one tick in 2**DIV_LOG2. The phase restarts at
// zero whenever division is off, so the first divided pulse comes on the
// 2**DIV_LOG2-th tick after division is turned on.
module evmon_prescale #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_on,
    input  logic tick,
    output logic pulse
);
    logic [DIV_LOG2-1:0] phase_q;

    // Advance the divider phase on counted ticks; hold at zero when undivided.
    always_ff @(posedge clk) begin
        if (!rst_n || !div_on)
            phase_q <= '0;
        else if (run && tick)
            phase_q <= phase_q + 1'b1;
    end

    assign pulse = run && tick && (!div_on || (phase_q == '1));
endmodule

// File: rtl/evmon_slot.sv
// One event counter with its event-type register. Selects its event source
// by number, filters it by privilege and implemented-event map, and counts.
// Assumes a software load wins over a simultaneous count step.
module evmon_slot #(
    parameter int          CNT_W    = 32,
    parameter int          NEVT     = 64,
    parameter logic [63:0] IMPL_MAP = 64'h0000_0001_0002_00FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic             slot_en,
    input  logic             wr_type,
    input  logic             wr_cnt,
    input  logic [31:0]      wdata,
    input  logic [NEVT-1:0]  events,
    input  logic             cyc_pulse,
    input  logic             priv,
    output logic [31:0]      type_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    import evmon_pkg::*;
    localparam int IDX_W = $clog2(NEVT);

    logic             no_priv_q, no_user_q;
    logic [7:0]       evnum_q;
    logic [CNT_W-1:0] cnt_q;
    logic             known, src, allow, step;

    // Hold the event-type fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_priv_q <= 1'b0;
            no_user_q <= 1'b0;
            evnum_q   <= '0;
        end else if (wr_type) begin
            no_priv_q <= wdata[TYPE_NOPRIV_BIT];
            no_user_q <= wdata[TYPE_NOUSER_BIT];
            evnum_q   <= wdata[7:0];
        end
    end

    // Decide whether this cycle carries a countable event for this slot.
    always_comb begin
        known = (32'(evnum_q) < NEVT) && IMPL_MAP[evnum_q[IDX_W-1:0]];
        src   = (evnum_q == CYCLE_EVT) ? cyc_pulse : events[evnum_q[IDX_W-1:0]];
        allow = priv ? !no_priv_q : !no_user_q;
        step  = glob_en && slot_en && known && allow && src;
    end

    // Load from software or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_cnt)
            cnt_q <= wdata[CNT_W-1:0];
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_o = step && !wr_cnt && (cnt_q == '1);
    assign type_o = {no_priv_q, no_user_q, 22'b0, evnum_q};
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/evmon_top.sv
// Event-counter performance monitor top: register decode, shared
// enable/interrupt/wrap state, indirect access through a select register,
// and a generated bank of counter slots. Reads are combinational.
module evmon_top #(
    parameter int          NCNT     = 4,
    parameter int          DIV_LOG2 = 6,
    parameter logic [63:0] IMPL_MAP = 64'h0000_0001_0002_00FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [63:0] events_in,
    input  logic        priv_mode,
    input  logic        cycle_tick,
    output logic        irq_o
);
    import evmon_pkg::*;
    localparam int CNT_W = 32;

    logic             run_q, div_q;
    logic [NCNT-1:0]  cnt_en_q, irq_en_q, wrap_q, wrap_hit;
    logic [SEL_W-1:0] sel_q;
    logic             sel_ok, cyc_pulse;
    logic [NCNT-1:0]  wr_type_v, wr_cnt_v;
    logic [31:0]      type_v [NCNT];
    logic [CNT_W-1:0] cnt_v  [NCNT];
    logic [NCNT*CNT_W-1:0] cnt_flat;

    assign sel_ok = (32'(sel_q) < NCNT);

    // Control, select and enable registers with set/clear semantics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            div_q    <= 1'b0;
            sel_q    <= '0;
            cnt_en_q <= '0;
            irq_en_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    run_q <= bus_wdata[CTRL_RUN_BIT];
                    div_q <= bus_wdata[CTRL_DIV_BIT];
                end
                A_SEL:   sel_q    <= bus_wdata[SEL_W-1:0];
                A_ENSET: cnt_en_q <= cnt_en_q | bus_wdata[NCNT-1:0];
                A_ENCLR: cnt_en_q <= cnt_en_q & ~bus_wdata[NCNT-1:0];
                A_IESET: irq_en_q <= irq_en_q | bus_wdata[NCNT-1:0];
                A_IECLR: irq_en_q <= irq_en_q & ~bus_wdata[NCNT-1:0];
                default: ;
            endcase
        end
    end

    // Wrap status: write-one-to-clear, a new wrap in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wrap_q <= '0;
        else if (bus_wr && bus_addr == A_WRAP)
            wrap_q <= (wrap_q & ~bus_wdata[NCNT-1:0]) | wrap_hit;
        else
            wrap_q <= wrap_q | wrap_hit;
    end

    evmon_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .div_on(div_q),
        .tick(cycle_tick), .pulse(cyc_pulse)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_slot
        assign wr_type_v[i] = bus_wr && (bus_addr == A_TYPE)  && sel_ok && (32'(sel_q) == i);
        assign wr_cnt_v[i]  = bus_wr && (bus_addr == A_COUNT) && sel_ok && (32'(sel_q) == i);
        evmon_slot #(.CNT_W(CNT_W), .NEVT(NUM_EVT), .IMPL_MAP(IMPL_MAP)) u_slot (
            .clk(clk), .rst_n(rst_n), .glob_en(run_q), .slot_en(cnt_en_q[i]),
            .wr_type(wr_type_v[i]), .wr_cnt(wr_cnt_v[i]), .wdata(bus_wdata),
            .events(events_in), .cyc_pulse(cyc_pulse), .priv(priv_mode),
            .type_o(type_v[i]), .cnt_o(cnt_v[i]), .wrap_o(wrap_hit[i])
        );
        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_v[i];
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  begin
                bus_rdata[CTRL_RUN_BIT] = run_q;
                bus_rdata[CTRL_DIV_BIT] = div_q;
            end
            A_ENSET, A_ENCLR: bus_rdata[NCNT-1:0] = cnt_en_q;
            A_IESET, A_IECLR: bus_rdata[NCNT-1:0] = irq_en_q;
            A_WRAP:  bus_rdata[NCNT-1:0] = wrap_q;
            A_SEL:   bus_rdata[SEL_W-1:0] = sel_q;
            A_TYPE:  if (sel_ok) bus_rdata = type_v[sel_q[$clog2(NCNT)-1:0]];
            A_COUNT: if (sel_ok) bus_rdata = cnt_v[sel_q[$clog2(NCNT)-1:0]];
            A_CAPLO: bus_rdata = IMPL_MAP[31:0];
            A_CAPHI: bus_rdata = IMPL_MAP[63:32];
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = |(wrap_q & irq_en_q);
endmodule

// File: rtl/evmon_chk.sv
// Assertion checker for evmon_top, attached by bind. Observes bus writes,
// the interrupt output and the counter, enable and wrap state.
module evmon_chk #(
    parameter int NCNT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_o,
    input logic              run_q,
    input logic [NCNT-1:0]   cnt_en_q,
    input logic [NCNT-1:0]   wrap_q,
    input logic [NCNT*32-1:0] cnt_flat
);
    import evmon_pkg::*;
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == A_COUNT);

    // R1
    halted_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_wr) |=> $stable(cnt_flat));

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IECLR && bus_wdata[NCNT-1:0] == '1) |=> !irq_o);

    // R5
    enset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENSET) |=> ((cnt_en_q & $past(bus_wdata[NCNT-1:0])) == $past(bus_wdata[NCNT-1:0])));

    for (genvar i = 0; i < NCNT; i++) begin : g_c
        // R6
        wrap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wrap_q[i]) |-> ($past(cnt_flat[i*32 +: 32]) == 32'hFFFF_FFFF));
        // R9
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_wr |=> (cnt_flat[i*32 +: 32] == $past(cnt_flat[i*32 +: 32])
                      || cnt_flat[i*32 +: 32] == $past(cnt_flat[i*32 +: 32]) + 32'd1));
    end
endmodule

bind evmon_top evmon_chk #(.NCNT(NCNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_o(irq_o), .run_q(run_q),
    .cnt_en_q(cnt_en_q), .wrap_q(wrap_q), .cnt_flat(cnt_flat)
);

// File: tb/evmon_top_test.sv
`timescale 1ns/1ps
module evmon_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] events_in = '0;
    logic        priv_mode = 1'b0;
    logic        cycle_tick = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    evmon_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .events_in(events_in),
        .priv_mode(priv_mode), .cycle_tick(cycle_tick), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // op: 0 write, 1 read-compare, 2 event pulse (data[5:0] index, data[8] priv), 3 irq compare
    function automatic logic [69:0] v(input logic [1:0] op, input logic [3:0] a,
                                      input logic [31:0] d, input logic [31:0] e);
        return {op, a, d, e};
    endfunction

    localparam int NV = 74;
    localparam logic [69:0] VEC [NV] = '{
        v(0,0,1,0),            // R1 run
        v(0,6,0,0), v(0,7,32'h3,0), v(0,8,0,0),
        v(0,6,1,0), v(0,7,32'h8000_0005,0), v(0,8,10,0),
        v(0,1,3,0),
        v(2,0,32'h003,0), v(2,0,32'h103,0),       // R9 two steps
        v(2,0,32'h005,0), v(2,0,32'h105,0),       // R3 priv blocked
        v(0,6,0,0), v(1,8,0,2),
        v(0,6,1,0), v(1,8,0,11), v(1,7,0,32'h8000_0005),
        v(0,2,1,0), v(1,1,0,2), v(1,2,0,2),        // R5
        v(2,0,32'h003,0), v(0,6,0,0), v(1,8,0,2),
        v(0,6,2,0), v(0,7,8,0), v(0,8,0,0), v(0,1,4,0),
        v(2,0,32'h008,0), v(1,8,0,0),              // R8 unimplemented
        v(0,7,32'h40,0), v(2,0,32'h000,0), v(1,8,0,0),   // R8 event 64
        v(0,6,3,0), v(0,7,32'h4000_0020,0), v(0,8,0,0), v(0,1,8,0),
        v(2,0,32'h020,0), v(2,0,32'h120,0), v(1,8,0,1),  // R3 user blocked
        v(0,0,0,0), v(2,0,32'h120,0), v(1,8,0,1), v(0,0,1,0), // R1
        v(0,6,5,0), v(1,8,0,0), v(1,7,0,0),        // R4 out of range
        v(0,8,32'h1234,0), v(0,7,32'hFF,0),
        v(0,6,3,0), v(1,8,0,1), v(1,7,0,32'h4000_0020),
        v(0,6,0,0), v(0,8,32'hFFFF_FFFE,0), v(0,1,1,0), v(0,3,1,0),
        v(2,0,32'h003,0), v(1,8,0,32'hFFFF_FFFF), v(1,5,0,0), v(3,0,0,0),
        v(2,0,32'h003,0), v(1,8,0,0), v(1,5,0,1), v(3,0,0,1), // R6 R7
        v(0,4,1,0), v(3,0,0,0), v(1,3,0,0), v(1,4,0,0),
        v(0,3,1,0), v(3,0,0,1),
        v(0,5,0,0), v(1,5,0,1), v(0,5,1,0), v(1,5,0,0), v(3,0,0,0)
    };

    function automatic string tag_of(input logic [1:0] op, input logic [3:0] a);
        if (op == 2'd3) return "R7";
        case (a)
            4'd8: return "R9";
            4'd5: return "R6";
            4'd7: return "R3";
            4'd9, 4'd10: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if (irq_o !== exp) begin
            fails++;
            $display("FAIL %s irq actual %b expected %b", tag, irq_o, exp);
        end
    endtask

    task automatic pulse(input logic [5:0] idx, input logic p);
        @(negedge clk);
        events_in = '0; events_in[idx] = 1'b1; priv_mode = p;
        @(negedge clk);
        events_in = '0; priv_mode = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cycle_tick = 1'b1;
        end
        @(negedge clk);
        cycle_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state, R8 capability map
        rd_chk(4'd0, 32'h0, "R10");
        rd_chk(4'd1, 32'h0, "R10");
        rd_chk(4'd5, 32'h0, "R10");
        rd_chk(4'd8, 32'h0, "R10");
        rd_chk(4'd9, 32'h0002_00FF, "R8");
        rd_chk(4'd10, 32'h0000_0001, "R8");

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  a;
            logic [31:0] d, e;
            {op, a, d, e} = VEC[i];
            case (op)
                2'd0: wr(a, d);
                2'd1: rd_chk(a, e, tag_of(op, a));
                2'd2: pulse(d[5:0], d[8]);
                default: irq_chk(e[0], "R7");
            endcase
        end

        // R2 cycle tick, undivided then divide by 64
        wr(4'd6, 1);
        wr(4'd7, 32'h11);
        wr(4'd8, 0);
        ticks(5);
        rd_chk(4'd8, 32'd5, "R2");
        wr(4'd0, 32'h9);
        ticks(63);
        rd_chk(4'd8, 32'd5, "R2");
        ticks(1);
        rd_chk(4'd8, 32'd6, "R2");

        // R10 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(4'd0, 32'h0, "R10");
        rd_chk(4'd1, 32'h0, "R10");
        rd_chk(4'd3, 32'h0, "R10");
        rd_chk(4'd6, 32'h0, "R10");
        rd_chk(4'd8, 32'h0, "R10");
        wr(4'd6, 1);
        rd_chk(4'd8, 32'h0, "R10");
        rd_chk(4'd7, 32'h0, "R10");
        irq_chk(1'b0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule